// File: doc/BRIEF.md
# Periodic Interrupt Generator with Missed-Tick Catch-Up

This block divides a 32768 Hz tick stream into a periodic interrupt whose period is picked by a 4-bit rate code. The interrupt is enabled by a single enable input. Each expiry raises two status flags: a summary interrupt flag and a periodic flag. It also drives the interrupt line and offers the interrupt to the interrupt controller through a one-cycle attempt strobe. The controller answers in the same cycle with an accept input. A status read clears both flags and drops the interrupt line.

In compensating mode (parameter `COMPENSATE = 1`), a periodic tick that the controller refuses is not lost. It is added to a missed-tick count, and that count is drained in two ways. A catch-up timer runs faster as the backlog grows. A status read can also reinject a tick, but only a fixed number of times before the next periodic tick re-arms that path. When the rate changes, the backlog is rescaled to the new period, so that the total elapsed time is preserved. In non-compensating mode nothing is counted, and a rate change never delays the next tick by more than one new period.

Top module: `periodic_irq_reinject`

## Requirements
- R1: After reset, `stat_flags` is 00, `irq` is 0, `irq_try` is 0 and `missed_cnt` is 0.
- R2: The period in ticks is 128 for code 1, 256 for code 2, and 2^(code-1) for codes 3 to 15. Code 0 or `pie`=0 stops the timer and gives no `irq_try`. The first expiry comes one full period after the enable cycle.
- R3: Every attempt (`irq_try`=1) sets `stat_flags` to 11 (bit 1 = interrupt summary, bit 0 = periodic) and raises `irq` on the next cycle.
- R4: A status read with no attempt in the same cycle clears `stat_flags` to 00 and drops `irq`. An attempt in the same cycle wins.
- R5: In compensating mode, a periodic expiry whose attempt is refused (`irq_accept`=0) raises `missed_cnt` by 1, saturating at its maximum. Without an attempt, a rescale or a disable, `missed_cnt` holds.
- R6: While `missed_cnt`=m is nonzero, a catch-up attempt fires after max(1, floor(P/(min(m,7)+1))) ticks. Its timer restarts from zero whenever m changes and after each firing. An accepted catch-up attempt lowers m by 1.
- R7: A status read with `pie`=1, m nonzero and fewer than 20 read reinjections since re-arm makes an attempt. If accepted, it lowers m by 1. A periodic expiry re-arms this path once the 20 have been used.
- R8: When the timer stops (`pie`=0 or code 0), `missed_cnt` and the period phase are cleared on the next cycle.
- R9: In compensating mode, a change from period Pold to Pnew with elapsed ticks E gives m' = (m*Pold+E)/Pnew. The remainder R becomes the new phase, so the next expiry comes after Pnew-R ticks.
- R10: In non-compensating mode `missed_cnt` stays 0. On a rate change the phase is kept if it is below Pnew, and otherwise becomes Pnew-1, so the next tick expires.
- R11: Expiry, catch-up and read reinjection in the same cycle merge into one attempt. A refused expiry counts +1. Otherwise an accepted catch-up or reinjection counts -1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_32k | input | 1 | One-cycle strobe at 32768 Hz |
| rate_code | input | 4 | Period select |
| pie | input | 1 | Periodic interrupt enable |
| stat_rd | input | 1 | Status register read strobe |
| irq_accept | input | 1 | Controller accepts the attempt in this cycle |
| irq | output | 1 | Interrupt line, follows the summary flag |
| irq_try | output | 1 | Delivery attempt this cycle |
| stat_flags | output | 2 | {summary flag, periodic flag} |
| missed_cnt | output | MISS_W | Missed-tick backlog |

## Verification
The bench targets these corner cases:
- A period change in the middle of an interval. A design that drops the remainder would deliver the next tick late.
- Catch-up firing in the same cycle as an expiry. A design that does not merge them would count twice or attempt twice.
- The twentieth read reinjection. An off-by-one would let one extra reinjection decrement the backlog.
- A tick that lands after the phase has been clamped in non-compensating mode. A design without the clamp would stretch the interval past one period.

Random enable, read, accept and tick patterns are compared cycle by cycle against a behavioural model. The model shows up any slip in catch-up spacing or backlog arithmetic.

// File: rtl/periodic_irq_reinject.sv
module periodic_irq_reinject #(
  parameter bit COMPENSATE = 1'b1,
  parameter int MISS_W     = 12,
  parameter int ACK_CAP    = 20,
  parameter int ACK_W      = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_32k,
  input  logic [3:0]        rate_code,
  input  logic              pie,
  input  logic              stat_rd,
  input  logic              irq_accept,
  output logic              irq,
  output logic              irq_try,
  output logic [1:0]        stat_flags,
  output logic [MISS_W-1:0] missed_cnt
);
  localparam int LEN_W = 15;
  localparam int PH_W  = 14;
  localparam int TOT_W = MISS_W + LEN_W + 1;
  localparam int MUL_W = LEN_W + 4;

  logic [3:0]        lg_now, lg_q;
  logic              on_now, on_q;
  logic [LEN_W-1:0]  len_now;
  logic [PH_W-1:0]   ph, ph_nxt;
  logic [LEN_W-1:0]  cu, cu_nxt;
  logic [MISS_W-1:0] miss_nxt;
  logic [ACK_W-1:0]  ack, ack_nxt;
  logic              irqf, pf;
  logic              chg, start, expire, catchup, reinj, inc, dec;
  logic [3:0]        cdiv;
  logic [LEN_W-1:0]  elapsed;
  logic [TOT_W-1:0]  total, shifted, rem;

  always_comb begin
    case (rate_code)
      4'd1:    lg_now = 4'd7;
      4'd2:    lg_now = 4'd8;
      default: lg_now = rate_code - 4'd1;
    endcase
  end

  assign on_now  = pie && (rate_code != 4'd0);
  assign len_now = LEN_W'(1) << lg_now;
  assign chg     = on_now && on_q && (lg_now != lg_q);
  assign start   = on_now && !on_q;
  assign elapsed = {1'b0, ph} + LEN_W'(tick_32k);
  assign cdiv    = (missed_cnt >= MISS_W'(7)) ? 4'd8 : 4'(missed_cnt) + 4'd1;

  assign expire  = on_now && on_q && !chg && tick_32k &&
                   (({1'b0, ph} + LEN_W'(1)) == len_now);
  assign catchup = COMPENSATE && on_now && on_q && !chg && (missed_cnt != '0) && tick_32k &&
                   ((MUL_W'(cu) + MUL_W'(2)) * MUL_W'(cdiv) > MUL_W'(len_now));
  assign reinj   = COMPENSATE && stat_rd && on_now && !chg && (missed_cnt != '0) &&
                   (ack < ACK_W'(ACK_CAP));
  assign irq_try = expire || catchup || reinj;
  assign inc     = COMPENSATE && expire && !irq_accept;
  assign dec     = (catchup || reinj) && irq_accept && !inc;

  assign total   = (TOT_W'(missed_cnt) << lg_q) + TOT_W'(elapsed);
  assign shifted = total >> lg_now;
  assign rem     = total & TOT_W'(len_now - LEN_W'(1));

  always_comb begin
    miss_nxt = missed_cnt;
    if (!on_now || start)
      miss_nxt = '0;
    else if (chg)
      miss_nxt = !COMPENSATE ? '0 :
                 (|(shifted >> MISS_W)) ? '1 : MISS_W'(shifted);
    else if (inc)
      miss_nxt = (missed_cnt == '1) ? missed_cnt : missed_cnt + MISS_W'(1);
    else if (dec)
      miss_nxt = missed_cnt - MISS_W'(1);
  end

  always_comb begin
    ph_nxt = ph;
    if (!on_now || start)
      ph_nxt = '0;
    else if (chg)
      ph_nxt = COMPENSATE ? PH_W'(rem) :
               (elapsed >= len_now) ? PH_W'(len_now - LEN_W'(1)) : PH_W'(elapsed);
    else if (expire)
      ph_nxt = '0;
    else if (tick_32k)
      ph_nxt = ph + PH_W'(1);
  end

  assign cu_nxt  = (!on_now || chg || catchup || (miss_nxt != missed_cnt) || (missed_cnt == '0)) ? '0 :
                   tick_32k ? cu + LEN_W'(1) : cu;
  assign ack_nxt = reinj ? ack + ACK_W'(1) :
                   (COMPENSATE && expire && (ack >= ACK_W'(ACK_CAP))) ? '0 : ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lg_q       <= '0;
      on_q       <= 1'b0;
      ph         <= '0;
      cu         <= '0;
      ack        <= '0;
      missed_cnt <= '0;
      irqf       <= 1'b0;
      pf         <= 1'b0;
    end else begin
      lg_q       <= lg_now;
      on_q       <= on_now;
      ph         <= ph_nxt;
      cu         <= cu_nxt;
      ack        <= ack_nxt;
      missed_cnt <= miss_nxt;
      irqf       <= irq_try ? 1'b1 : stat_rd ? 1'b0 : irqf;
      pf         <= irq_try ? 1'b1 : stat_rd ? 1'b0 : pf;
    end
  end

  assign irq        = irqf;
  assign stat_flags = {irqf, pf};
endmodule

// File: rtl/periodic_irq_reinject_chk.sv
module periodic_irq_reinject_chk #(
  parameter int MISS_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_32k,
  input logic [3:0]        rate_code,
  input logic              pie,
  input logic              stat_rd,
  input logic              irq_accept,
  input logic              irq,
  input logic              irq_try,
  input logic [1:0]        stat_flags,
  input logic [MISS_W-1:0] missed_cnt
);
  p_flags_after_try_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_try |=> (stat_flags == 2'b11) && irq);

  p_read_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !irq_try) |=> (stat_flags == 2'b00) && !irq);

  p_off_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !pie |=> (missed_cnt == '0));

  p_quiet_when_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !pie |-> !irq_try);

  p_hold_without_try_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pie && $past(pie) && (rate_code == $past(rate_code)) && (rate_code != 4'd0) && !irq_try)
      |=> $stable(missed_cnt));

  p_no_rise_without_try_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pie && $past(pie) && (rate_code == $past(rate_code)) && (rate_code != 4'd0) && irq_try && irq_accept)
      |=> (missed_cnt <= $past(missed_cnt)));

  logic unused_ok;
  assign unused_ok = &{1'b0, tick_32k, stat_rd};
endmodule

bind periodic_irq_reinject periodic_irq_reinject_chk #(.MISS_W(MISS_W)) u_chk (.*);

// File: tb/test_periodic_irq_reinject.sv
module test_periodic_irq_reinject;
  localparam int CLK_P  = 10;
  localparam int MISS_W = 12;
  localparam int MMAX   = (1 << MISS_W) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 1'b0, pie = 1'b0, rd = 1'b0, acc = 1'b0;
  logic [3:0] code = 4'd0;
  logic irq_c, try_c, irq_n, try_n;
  logic [1:0] fl_c, fl_n;
  logic [MISS_W-1:0] ms_c, ms_n;

  always #(CLK_P/2) clk = ~clk;

  periodic_irq_reinject #(.COMPENSATE(1'b1), .MISS_W(MISS_W)) i_periodic_irq_reinject (
    .clk(clk), .rst_n(rst_n), .tick_32k(tick), .rate_code(code), .pie(pie),
    .stat_rd(rd), .irq_accept(acc), .irq(irq_c), .irq_try(try_c),
    .stat_flags(fl_c), .missed_cnt(ms_c));

  periodic_irq_reinject #(.COMPENSATE(1'b0), .MISS_W(MISS_W)) i_periodic_irq_reinject_nc (
    .clk(clk), .rst_n(rst_n), .tick_32k(tick), .rate_code(code), .pie(pie),
    .stat_rd(rd), .irq_accept(acc), .irq(irq_n), .irq_try(try_n),
    .stat_flags(fl_n), .missed_cnt(ms_n));

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  string tag = "R1";

  int ph[2], ms[2], cu[2], ak[2], fi[2], fp[2], lgq[2], onq[2];
  bit e_exp[2], e_cf[2], e_ar[2], e_try[2], e_chg[2], e_on[2];
  int e_lg[2];
  bit lt[2];
  logic [3:0] nx_code = 4'd0;
  logic nx_pie = 1'b0;

  function automatic int lg_of(input int c);
    if (c == 1) return 7;
    if (c == 2) return 8;
    return c - 1;
  endfunction

  task automatic chk(input string req, input int got, input int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  task automatic mreset();
    for (int m = 0; m < 2; m++) begin
      ph[m] = 0; ms[m] = 0; cu[m] = 0; ak[m] = 0; fi[m] = 0; fp[m] = 0; lgq[m] = 0; onq[m] = 0;
    end
  endtask

  task automatic mcomb(input int m);
    bit comp; int len, c;
    comp = (m == 0);
    e_lg[m] = lg_of(code);
    len = 1 << e_lg[m];
    e_on[m] = pie && code != 0;
    e_chg[m] = e_on[m] && onq[m] != 0 && e_lg[m] != lgq[m];
    e_exp[m] = e_on[m] && onq[m] != 0 && !e_chg[m] && tick && (ph[m] + 1 == len);
    c = (ms[m] >= 7) ? 8 : ms[m] + 1;
    e_cf[m] = comp && e_on[m] && onq[m] != 0 && !e_chg[m] && ms[m] != 0 && tick && ((cu[m] + 2) * c > len);
    e_ar[m] = comp && rd && e_on[m] && !e_chg[m] && ms[m] != 0 && ak[m] < 20;
    e_try[m] = e_exp[m] || e_cf[m] || e_ar[m];
  endtask

  task automatic mupd(input int m);
    bit comp, inc, dec; int len, nm, np, el;
    longint tot;
    comp = (m == 0);
    len = 1 << e_lg[m];
    inc = comp && e_exp[m] && !acc;
    dec = (e_cf[m] || e_ar[m]) && acc && !inc;
    el = ph[m] + (tick ? 1 : 0);
    nm = ms[m]; np = ph[m];
    if (!e_on[m] || onq[m] == 0) begin nm = 0; np = 0; end
    else if (e_chg[m]) begin
      if (comp) begin
        tot = longint'(ms[m]) * (longint'(1) << lgq[m]) + el;
        nm = (tot / len > MMAX) ? MMAX : int'(tot / len);
        np = int'(tot % len);
      end else begin
        nm = 0;
        np = (el >= len) ? len - 1 : el;
      end
    end else begin
      if (inc) nm = (ms[m] == MMAX) ? MMAX : ms[m] + 1;
      else if (dec) nm = ms[m] - 1;
      if (e_exp[m]) np = 0; else if (tick) np = ph[m] + 1;
    end
    if (!e_on[m] || e_chg[m] || e_cf[m] || nm != ms[m] || ms[m] == 0) cu[m] = 0;
    else if (tick) cu[m] = cu[m] + 1;
    if (e_ar[m]) ak[m] = ak[m] + 1;
    else if (comp && e_exp[m] && ak[m] >= 20) ak[m] = 0;
    if (e_try[m]) begin fi[m] = 1; fp[m] = 1; end
    else if (rd) begin fi[m] = 0; fp[m] = 0; end
    ms[m] = nm; ph[m] = np; lgq[m] = e_lg[m]; onq[m] = e_on[m] ? 1 : 0;
  endtask

  task automatic cyc(input bit t, input bit r, input bit a);
    @(negedge clk);
    chk(tag, ms_c, ms[0]);
    chk(tag, ms_n, ms[1]);
    chk(tag, {irq_c, fl_c}, {fi[0][0], fi[0][0], fp[0][0]});
    chk(tag, {irq_n, fl_n}, {fi[1][0], fi[1][0], fp[1][0]});
    tick = t; rd = r; acc = a; code = nx_code; pie = nx_pie;
    #1;
    mcomb(0); mcomb(1);
    chk(tag, try_c, e_try[0]);
    chk(tag, try_n, e_try[1]);
    lt[0] = try_c; lt[1] = try_n;
    @(posedge clk);
    mupd(0); mupd(1);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; tick = 0; rd = 0; acc = 0; nx_pie = 0; nx_code = 0; pie = 0; code = 0;
    mreset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  int n;

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    @(negedge clk);
    // R1 reset state
    chk("R1", {irq_c, try_c, fl_c}, 0);
    chk("R1", ms_c, 0);

    // R2: period length, code 3 = 4 ticks, code 1 = 128 ticks
    tag = "R2";
    nx_code = 4'd3; nx_pie = 1; cyc(1, 0, 1);
    n = 0; do begin cyc(1, 0, 1); n++; end while (!lt[0] && n < 1000);
    chk("R2", n, 4);
    n = 0; do begin cyc(1, 0, 1); n++; end while (!lt[0] && n < 1000);
    chk("R2", n, 4);
    nx_code = 4'd1; cyc(0, 1, 1);
    n = 0; do begin cyc(1, 0, 1); n++; end while (!lt[0] && n < 1000);
    chk("R2", n, 128);
    nx_code = 4'd0; n = 0;
    for (int i = 0; i < 300; i++) begin cyc(1, 0, 1); if (lt[0] || lt[1]) n++; end
    chk("R2", n, 0);

    // R3 / R4: flags after try, cleared by read
    tag = "R3"; nx_code = 4'd3;
    do cyc(1, 0, 1); while (!lt[0]);
    cyc(0, 0, 1);
    chk("R3", {irq_c, fl_c}, 3'b111);
    tag = "R4"; cyc(0, 1, 1); cyc(0, 0, 1);
    chk("R4", {irq_c, fl_c}, 3'b000);

    // R5 / R6: refused expiry, then catch-up after 2 ticks at m=1, P=4
    do_reset(); tag = "R5"; nx_code = 4'd3; nx_pie = 1; cyc(0, 0, 0);
    do cyc(1, 0, 0); while (!lt[0]);
    cyc(0, 0, 1);
    chk("R5", ms_c, 1);
    tag = "R6";
    n = 0; do begin cyc(1, 0, 1); n++; end while (!lt[0] && n < 100);
    chk("R6", n, 2);
    cyc(0, 0, 1);
    chk("R6", ms_c, 0);

    // R9: m=1 at P=8, phase 3, switch to P=4 -> m=2, next tick expires
    do_reset(); tag = "R9"; nx_code = 4'd4; nx_pie = 1; cyc(0, 0, 0);
    do cyc(1, 0, 0); while (!lt[0]);
    repeat (3) cyc(1, 0, 0);
    nx_code = 4'd3; cyc(0, 0, 0);
    cyc(0, 0, 0);
    chk("R9", ms_c, 2);
    cyc(1, 0, 0);
    chk("R9", lt[0], 1);

    // R10: non-compensating clamp, phase 7 at P=8 switched to P=4
    do_reset(); tag = "R10"; nx_code = 4'd4; nx_pie = 1; cyc(0, 0, 0);
    do cyc(1, 0, 1); while (!lt[1]);
    repeat (7) cyc(1, 0, 1);
    nx_code = 4'd3; cyc(0, 0, 1);
    cyc(1, 0, 1);
    chk("R10", lt[1], 1);
    chk("R10", ms_n, 0);

    // R7: read reinjection capped at 20, re-armed by an expiry
    do_reset(); tag = "R7"; nx_code = 4'd3; nx_pie = 1; cyc(0, 0, 0);
    repeat (120) cyc(1, 0, 0);
    cyc(0, 0, 0);
    chk("R7", ms_c, 30);
    repeat (25) cyc(0, 1, 1);
    cyc(0, 0, 1);
    chk("R7", ms_c, 10);
    n = 0; do begin cyc(1, 0, 0); n++; end while (ms[0] == 10 && n < 100);
    cyc(0, 0, 1);
    chk("R7", ms_c, 11);
    cyc(0, 1, 1); cyc(0, 0, 1);
    chk("R7", ms_c, 10);

    // R8: disabling clears the backlog
    tag = "R8"; nx_pie = 0; cyc(1, 0, 0); cyc(0, 0, 0);
    chk("R8", ms_c, 0);

    // R11: random mix, lockstep with the model
    do_reset(); tag = "R11";
    void'($urandom(32'd20240611));
    nx_code = 4'd3; nx_pie = 1;
    for (int i = 0; i < 20000; i++) begin
      if ($urandom_range(0, 299) == 0) nx_code = 4'($urandom_range(3, 6));
      if ($urandom_range(0, 999) == 0) nx_pie = ~nx_pie;
      cyc($urandom_range(0, 9) < 7, $urandom_range(0, 9) < 2, $urandom_range(0, 9) < 4);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule